// File: doc/BRIEF.md
# Pipeline Hazard Stall Calculator

This block does the cycle accounting for an in-order 32-bit processor. Each issued instruction arrives as a descriptor over a valid/ready handshake. The descriptor lists the registers the instruction reads and writes, whether it reads or writes memory, whether it jumps or multiplies, and whether it is a multi-register block load or store. For block moves it also gives the last register of the range and the low address bits. It also carries bits 4:1 of the program counter. The block compares the descriptor with a short history of recently modified registers and recently block-loaded registers. From that it returns the number of stall cycles that must be inserted before the instruction. It also adds each hazard category's penalty to a running per-category counter.

Register numbers form a 32-bit mask. General registers use indices 0 to 15, and special register n uses index 16+n. Index 16 is used to mark "the previous instruction was a jump". Index 20 marks "memory was written". Index 23 is the multiply-overflow register. The modification history is two stages deep and the block-load history is three stages deep. Stage 0 is always the most recent. When a descriptor needs stall cycles, `in_ready` drops for exactly that many cycles. Each of those cycles ages both histories by one empty stage. After that the instruction's own masks enter stage 0.

Top module: `hz_stall_unit`

## Requirements
- R1: After synchronous reset, both histories and all counters are zero, `in_ready` is high, and a descriptor with no flags set reports 0 stalls.
- R2: If a source or input-destination register was written by a block load 1, 2 or 3 instructions back, the stall is 3, 2 or 1 cycles. Only the nearest load counts, and with two operands the larger penalty applies.
- R3: A memory access whose address register was modified by the previous instruction stalls 1 cycle.
- R4: A memory read stalls 2 cycles if either of the two previous instructions wrote memory.
- R5: A jump through a register stalls 2 cycles if that register was modified by the previous instruction, or 1 cycle if it was modified two instructions back.
- R6: A multiply stalls 1 cycle if either operand was modified by the previous instruction. A multiply also marks index 23 (the overflow register) as modified.
- R7: Directly after a jump, an instruction with a 16-bit immediate stalls 1 cycle when `pc_lo` (PC[4:1]) is 4'hF. One with a 32-bit immediate stalls 1 cycle when `pc_lo` is 4'hE. Other alignments do not stall.
- R8: A block store of registers 0..`blk_last` stalls 2 cycles if any of them was modified by the previous instruction, or 1 cycle if one was modified two back.
- R9: A block load or store adds 1 or 2 cycles when the byte span from `blk_lo` to `blk_lo`+4*(`blk_last`+1)-1 crosses one or two 32-byte line boundaries.
- R10: An ordinary register write to index 16 or 20 sets no jump marker and no memory-write marker.
- R11: The reported stall is the largest ordering penalty among R2–R8, plus the line penalty of R9.
- R12: `in_ready` stays low for exactly the reported number of cycles. Each stall cycle ages both histories by one empty stage. Cycles with no descriptor do not age them.
- R13: On acceptance, each category counter adds its own penalty. The counters are 16-bit fields of `stall_cnt_o`, with field k at bits [16k+15:16k]. The order is: 0 block-load use, 1 address source, 2 read after write, 3 jump source, 4 multiply source, 5 jump target, 6 block-store source, 7 line crossing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Descriptor present |
| in_ready | output | 1 | Descriptor accepted when high with in_valid |
| src_en | input | 1 | Source register is used |
| src_idx | input | 5 | Source register index |
| dsti_en | input | 1 | Destination register is also read |
| dsti_idx | input | 5 | Read destination index |
| dsto_en | input | 1 | Instruction writes a register |
| dsto_idx | input | 5 | Written register index |
| mem_rd | input | 1 | Instruction reads memory |
| mem_wr | input | 1 | Instruction writes memory |
| addr_en | input | 1 | Memory address comes from a register |
| addr_idx | input | 5 | Address register index |
| jump | input | 1 | Instruction is a jump |
| jreg_en | input | 1 | Jump target comes from a register |
| jreg_idx | input | 5 | Jump register index |
| mul | input | 1 | Instruction is a multiply |
| mul_a_idx | input | 5 | First multiply operand |
| mul_b_idx | input | 5 | Second multiply operand |
| imm16 | input | 1 | Carries a 16-bit immediate |
| imm32 | input | 1 | Carries a 32-bit immediate |
| pc_lo | input | 4 | PC bits 4:1 |
| blk_load | input | 1 | Block load of registers 0..blk_last |
| blk_store | input | 1 | Block store of registers 0..blk_last |
| blk_last | input | 4 | Highest register of the block move |
| blk_lo | input | 5 | Address bits 4:0 of the block move |
| stall_o | output | 3 | Stall count for the presented descriptor |
| stall_cnt_o | output | 128 | Eight 16-bit per-category stall counters |

## Verification
Ordering penalties and the line-crossing penalty can fall on the same instruction. One test builds this with a block store whose low registers were just modified and whose span crosses a line, and expects the sum (2+1). Two ordering hazards can also hit the same instruction. Another test builds this with a read whose source and address register both come from the previous block load, and expects only the larger penalty (3). In both cases the bench checks the reported count and the number of cycles `in_ready` stays low.

// File: rtl/hz_pkg.sv
package hz_pkg;

    localparam int NREG    = 32;
    localparam int IDX_W   = 5;
    localparam int PEN_W   = 3;
    localparam int NCAT    = 8;
    localparam int BIT_JMP = 16;
    localparam int BIT_MWR = 20;
    localparam int BIT_MOF = 23;
    localparam int LINE_SH = 5;

    typedef logic [NREG-1:0]  rmask_t;
    typedef logic [PEN_W-1:0] pen_t;
    typedef logic [IDX_W-1:0] ridx_t;

    typedef enum logic [2:0] {
        CAT_LOADUSE = 3'd0,
        CAT_ADDRSRC = 3'd1,
        CAT_MEMRAW  = 3'd2,
        CAT_JMPSRC  = 3'd3,
        CAT_MULSRC  = 3'd4,
        CAT_JMPTGT  = 3'd5,
        CAT_BLKSRC  = 3'd6,
        CAT_BLKLINE = 3'd7
    } cat_e;

    typedef struct packed {
        logic       src_en;
        ridx_t      src;
        logic       dsti_en;
        ridx_t      dsti;
        logic       dsto_en;
        ridx_t      dsto;
        logic       mem_rd;
        logic       mem_wr;
        logic       addr_en;
        ridx_t      addr;
        logic       jump;
        logic       jreg_en;
        ridx_t      jreg;
        logic       mul;
        ridx_t      mul_a;
        ridx_t      mul_b;
        logic       imm16;
        logic       imm32;
        logic [3:0] pc_lo;
        logic       blk_ld;
        logic       blk_st;
        logic [3:0] blk_last;
        logic [4:0] blk_lo;
    } desc_t;

    function automatic rmask_t idx_bit(input logic en, input ridx_t idx);
        return en ? (rmask_t'(1) << idx) : '0;
    endfunction

    // registers 0..last
    function automatic rmask_t range_mask(input logic [3:0] last);
        return (rmask_t'(1) << ({1'b0, last} + 5'd1)) - rmask_t'(1);
    endfunction

    // number of 32-byte boundaries crossed by a block of last+1 words
    function automatic logic [1:0] lines_crossed(input logic [4:0] lo,
                                                 input logic [3:0] last);
        logic [6:0] end_b;
        end_b = {2'b00, lo} + ({3'b000, last} + 7'd1) * 7'd4 - 7'd1;
        return end_b[6:LINE_SH];
    endfunction

endpackage

// File: rtl/hz_history.sv
module hz_history
    import hz_pkg::*;
#(
    parameter int DEPTH = 3
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 shift,
    input  rmask_t               ins,
    output rmask_t [DEPTH-1:0]   hist
);

    rmask_t [DEPTH-1:0] stage_q;

    genvar s;
    generate
        for (s = 0; s < DEPTH; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) begin
                    stage_q[s] <= '0;
                end else if (shift) begin
                    if (s == 0) stage_q[s] <= ins;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign hist = stage_q;

    // R12
    idle_no_age_chk: assert property (@(posedge clk) disable iff (rst)
        !shift |=> $stable(stage_q));

endmodule

// File: rtl/hz_rules.sv
module hz_rules
    import hz_pkg::*;
#(
    parameter int MOD_DEPTH = 2,
    parameter int LD_DEPTH  = 3
) (
    input  desc_t                        d,
    input  rmask_t [MOD_DEPTH-1:0]       mod_h,
    input  rmask_t [LD_DEPTH-1:0]        ld_h,
    output logic   [NCAT-1:0][PEN_W-1:0] cat_pen,
    output pen_t                         total,
    output rmask_t                       mod_self,
    output rmask_t                       ld_self
);

    rmask_t blk_m;
    rmask_t mul_m;
    pen_t   hz_max;
    pen_t   pen_src, pen_dsti;
    logic   tgt_hit;

    assign blk_m = range_mask(d.blk_last);
    assign mul_m = idx_bit(1'b1, d.mul_a) | idx_bit(1'b1, d.mul_b);

    always_comb begin
        cat_pen  = '0;
        pen_src  = '0;
        pen_dsti = '0;

        // block-load use: nearest stage wins (loop runs oldest first)
        for (int k = LD_DEPTH - 1; k >= 0; k--) begin
            if (d.src_en && ld_h[k][d.src])   pen_src  = pen_t'(LD_DEPTH - k);
            if (d.dsti_en && ld_h[k][d.dsti]) pen_dsti = pen_t'(LD_DEPTH - k);
        end
        cat_pen[CAT_LOADUSE] = (pen_src > pen_dsti) ? pen_src : pen_dsti;

        if ((d.mem_rd || d.mem_wr) && d.addr_en && mod_h[0][d.addr])
            cat_pen[CAT_ADDRSRC] = pen_t'(1);

        if (d.mem_rd) begin
            for (int k = 0; k < MOD_DEPTH; k++)
                if (mod_h[k][BIT_MWR]) cat_pen[CAT_MEMRAW] = pen_t'(2);
        end

        for (int k = MOD_DEPTH - 1; k >= 0; k--) begin
            if (d.jreg_en && mod_h[k][d.jreg])
                cat_pen[CAT_JMPSRC] = pen_t'(MOD_DEPTH - k);
            if (d.blk_st && |(mod_h[k] & blk_m))
                cat_pen[CAT_BLKSRC] = pen_t'(MOD_DEPTH - k);
        end

        if (d.mul && |(mod_h[0] & mul_m))
            cat_pen[CAT_MULSRC] = pen_t'(1);

        if (tgt_hit)
            cat_pen[CAT_JMPTGT] = pen_t'(1);

        if (d.blk_ld || d.blk_st)
            cat_pen[CAT_BLKLINE] = pen_t'(lines_crossed(d.blk_lo, d.blk_last));
    end

    assign tgt_hit = mod_h[0][BIT_JMP] &&
                     ((d.imm16 && d.pc_lo == 4'hF) || (d.imm32 && d.pc_lo == 4'hE));

    always_comb begin
        hz_max = '0;
        for (int c = 0; c < NCAT - 1; c++)
            if (cat_pen[c] > hz_max) hz_max = cat_pen[c];
    end

    assign total = hz_max + cat_pen[CAT_BLKLINE];

    always_comb begin
        mod_self = idx_bit(d.dsto_en, d.dsto);
        mod_self[BIT_JMP] = d.jump;
        mod_self[BIT_MWR] = d.mem_wr;
        if (d.mul)    mod_self[BIT_MOF] = 1'b1;
        if (d.blk_ld) mod_self = mod_self | blk_m;
    end

    assign ld_self = d.blk_ld ? blk_m : '0;

endmodule

// File: rtl/hz_counters.sv
module hz_counters
    import hz_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         en,
    input  logic   [NCAT-1:0][PEN_W-1:0] inc,
    output logic   [NCAT-1:0][CW-1:0]    cnt
);

    genvar c;
    generate
        for (c = 0; c < NCAT; c++) begin : g_cnt
            always_ff @(posedge clk) begin
                if (rst)     cnt[c] <= '0;
                else if (en) cnt[c] <= cnt[c] + CW'(inc[c]);
            end
        end
    endgenerate

    // R13
    cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(cnt));

endmodule

// File: rtl/hz_stall_unit.sv
module hz_stall_unit
    import hz_pkg::*;
#(
    parameter int CNT_W     = 16,
    parameter int MOD_DEPTH = 2,
    parameter int LD_DEPTH  = 3
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   in_valid,
    output logic                   in_ready,
    input  logic                   src_en,
    input  logic [4:0]             src_idx,
    input  logic                   dsti_en,
    input  logic [4:0]             dsti_idx,
    input  logic                   dsto_en,
    input  logic [4:0]             dsto_idx,
    input  logic                   mem_rd,
    input  logic                   mem_wr,
    input  logic                   addr_en,
    input  logic [4:0]             addr_idx,
    input  logic                   jump,
    input  logic                   jreg_en,
    input  logic [4:0]             jreg_idx,
    input  logic                   mul,
    input  logic [4:0]             mul_a_idx,
    input  logic [4:0]             mul_b_idx,
    input  logic                   imm16,
    input  logic                   imm32,
    input  logic [3:0]             pc_lo,
    input  logic                   blk_load,
    input  logic                   blk_store,
    input  logic [3:0]             blk_last,
    input  logic [4:0]             blk_lo,
    output logic [PEN_W-1:0]       stall_o,
    output logic [NCAT*CNT_W-1:0]  stall_cnt_o
);

    desc_t d;
    assign d = '{src_en: src_en, src: src_idx, dsti_en: dsti_en, dsti: dsti_idx,
                 dsto_en: dsto_en, dsto: dsto_idx, mem_rd: mem_rd, mem_wr: mem_wr,
                 addr_en: addr_en, addr: addr_idx, jump: jump, jreg_en: jreg_en,
                 jreg: jreg_idx, mul: mul, mul_a: mul_a_idx, mul_b: mul_b_idx,
                 imm16: imm16, imm32: imm32, pc_lo: pc_lo, blk_ld: blk_load,
                 blk_st: blk_store, blk_last: blk_last, blk_lo: blk_lo};

    rmask_t [MOD_DEPTH-1:0]       mod_hist;
    rmask_t [LD_DEPTH-1:0]        ld_hist;
    logic   [NCAT-1:0][PEN_W-1:0] cat_pen;
    logic   [NCAT-1:0][CNT_W-1:0] cnt;
    pen_t   total;
    rmask_t mod_self, ld_self;

    logic   busy;
    pen_t   rem;
    rmask_t pend_mod, pend_ld;
    logic   accept, shift;
    rmask_t mod_ins, ld_ins;

    assign in_ready = !busy;
    assign accept   = in_valid && !busy;
    assign shift    = accept || busy;

    hz_rules #(.MOD_DEPTH(MOD_DEPTH), .LD_DEPTH(LD_DEPTH)) u_rules (
        .d(d), .mod_h(mod_hist), .ld_h(ld_hist), .cat_pen(cat_pen),
        .total(total), .mod_self(mod_self), .ld_self(ld_self)
    );

    always_comb begin
        mod_ins = '0;
        ld_ins  = '0;
        if (accept && total == '0) begin
            mod_ins = mod_self;
            ld_ins  = ld_self;
        end else if (busy && rem == '0) begin
            mod_ins = pend_mod;
            ld_ins  = pend_ld;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy     <= 1'b0;
            rem      <= '0;
            pend_mod <= '0;
            pend_ld  <= '0;
        end else if (accept && total != '0) begin
            busy     <= 1'b1;
            rem      <= total - pen_t'(1);
            pend_mod <= mod_self;
            pend_ld  <= ld_self;
        end else if (busy) begin
            if (rem == '0) busy <= 1'b0;
            else           rem  <= rem - pen_t'(1);
        end
    end

    hz_history #(.DEPTH(MOD_DEPTH)) u_mod_hist (
        .clk(clk), .rst(rst), .shift(shift), .ins(mod_ins), .hist(mod_hist)
    );

    hz_history #(.DEPTH(LD_DEPTH)) u_ld_hist (
        .clk(clk), .rst(rst), .shift(shift), .ins(ld_ins), .hist(ld_hist)
    );

    hz_counters #(.CW(CNT_W)) u_cnt (
        .clk(clk), .rst(rst), .en(accept), .inc(cat_pen), .cnt(cnt)
    );

    assign stall_o     = total;
    assign stall_cnt_o = cnt;

    // R12
    stall_blocks_chk: assert property (@(posedge clk) disable iff (rst)
        accept && total != '0 |=> !in_ready);

    // R12
    drain_ends_chk: assert property (@(posedge clk) disable iff (rst)
        busy && rem == '0 |=> in_ready);

    // R12
    empty_stage_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && rem != '0) || (accept && total != '0)
        |=> mod_hist[0] == '0 && ld_hist[0] == '0);

    // R2
    loaduse_chk: assert property (@(posedge clk) disable iff (rst)
        accept && src_en && ld_hist[0][src_idx] |-> stall_o >= pen_t'(3));

    // R4
    memraw_chk: assert property (@(posedge clk) disable iff (rst)
        accept && mem_rd && (mod_hist[0][BIT_MWR] || mod_hist[1][BIT_MWR])
        |-> stall_o >= pen_t'(2));

endmodule

// File: tb/hz_stall_unit_tb.sv
`timescale 1ns/1ps
module hz_stall_unit_tb;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic in_valid, in_ready;
    logic src_en, dsti_en, dsto_en, mem_rd, mem_wr, addr_en, jump, jreg_en;
    logic mul, imm16, imm32, blk_load, blk_store;
    logic [4:0] src_idx, dsti_idx, dsto_idx, addr_idx, jreg_idx, mul_a_idx, mul_b_idx;
    logic [4:0] blk_lo;
    logic [3:0] pc_lo, blk_last;
    logic [2:0] stall_o;
    logic [127:0] stall_cnt_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    hz_stall_unit u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .src_en(src_en), .src_idx(src_idx), .dsti_en(dsti_en), .dsti_idx(dsti_idx),
        .dsto_en(dsto_en), .dsto_idx(dsto_idx), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .addr_en(addr_en), .addr_idx(addr_idx), .jump(jump), .jreg_en(jreg_en),
        .jreg_idx(jreg_idx), .mul(mul), .mul_a_idx(mul_a_idx), .mul_b_idx(mul_b_idx),
        .imm16(imm16), .imm32(imm32), .pc_lo(pc_lo), .blk_load(blk_load),
        .blk_store(blk_store), .blk_last(blk_last), .blk_lo(blk_lo),
        .stall_o(stall_o), .stall_cnt_o(stall_cnt_o)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic clr();
        {src_en, dsti_en, dsto_en, mem_rd, mem_wr, addr_en, jump, jreg_en} = '0;
        {mul, imm16, imm32, blk_load, blk_store} = '0;
        {src_idx, dsti_idx, dsto_idx, addr_idx, jreg_idx, mul_a_idx, mul_b_idx} = '0;
        blk_lo = '0; pc_lo = '0; blk_last = '0;
    endtask

    task automatic do_reset();
        in_valid = 1'b0;
        clr();
        @(negedge clk); rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    // present descriptor, check count, then count cycles with in_ready low
    task automatic go(input int exp, input string tag);
        int n;
        in_valid = 1'b1;
        #1;
        chk(in_ready === 1'b1, {tag, " ready"}, int'(in_ready), 1);
        chk(stall_o == 3'(exp), tag, int'(stall_o), exp);
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        clr();
        n = 0;
        while (!in_ready && n < 20) begin
            n++;
            @(negedge clk);
        end
        chk(n == exp, {tag, " ready-low cycles"}, n, exp);
    endtask

    task automatic t_reset();
        do_reset();
        chk(in_ready === 1'b1, "R1 ready after reset", int'(in_ready), 1);
        chk(stall_cnt_o == '0, "R1 counters clear", int'(stall_cnt_o[31:0]), 0);
        go(0, "R1 empty descriptor");
    endtask

    task automatic t_loaduse();
        do_reset();
        blk_load = 1; blk_last = 0; go(0, "R2 load r0");
        src_en = 1; src_idx = 0; go(3, "R2 use 1 back");
        do_reset();
        blk_load = 1; go(0, "R2 load");
        go(0, "R2 gap");
        src_en = 1; src_idx = 0; go(2, "R2 use 2 back");
        do_reset();
        blk_load = 1; go(0, "R2 load");
        go(0, "R2 gap");
        go(0, "R2 gap");
        src_en = 1; src_idx = 0; go(1, "R2 use 3 back");
        do_reset();
        blk_load = 1; blk_last = 2; go(0, "R2 load r0..r2");
        src_en = 1; src_idx = 5; dsti_en = 1; dsti_idx = 1; go(3, "R2 dest operand");
    endtask

    task automatic t_simple();
        do_reset();
        dsto_en = 1; dsto_idx = 7; go(0, "R3 write r7");
        mem_rd = 1; addr_en = 1; addr_idx = 7; go(1, "R3 address source");
        do_reset();
        mem_wr = 1; go(0, "R4 write");
        mem_rd = 1; go(2, "R4 read after write");
        mem_rd = 1; go(0, "R12 aged by stall");
        do_reset();
        mem_wr = 1; go(0, "R4 write");
        go(0, "R4 gap");
        mem_rd = 1; go(2, "R4 two back");
        do_reset();
        dsto_en = 1; dsto_idx = 5; go(0, "R5 write r5");
        jump = 1; jreg_en = 1; jreg_idx = 5; go(2, "R5 jump 1 back");
        do_reset();
        dsto_en = 1; dsto_idx = 5; go(0, "R5 write r5");
        go(0, "R5 gap");
        jump = 1; jreg_en = 1; jreg_idx = 5; go(1, "R5 jump 2 back");
        do_reset();
        dsto_en = 1; dsto_idx = 3; go(0, "R6 write r3");
        mul = 1; mul_a_idx = 4; mul_b_idx = 3; go(1, "R6 operand");
        mul = 1; mul_a_idx = 23; mul_b_idx = 9; go(1, "R6 overflow reg marked");
    endtask

    task automatic t_jump_target();
        do_reset();
        jump = 1; go(0, "R7 jump");
        imm16 = 1; pc_lo = 4'hF; go(1, "R7 imm16 at F");
        jump = 1; go(0, "R7 jump");
        imm16 = 1; pc_lo = 4'hE; go(0, "R7 imm16 at E");
        jump = 1; go(0, "R7 jump");
        imm32 = 1; pc_lo = 4'hE; go(1, "R7 imm32 at E");
        imm32 = 1; pc_lo = 4'hE; go(0, "R7 no preceding jump");
        do_reset();
        dsto_en = 1; dsto_idx = 16; go(0, "R10 write idx16");
        imm16 = 1; pc_lo = 4'hF; go(0, "R10 no jump marker");
        dsto_en = 1; dsto_idx = 20; go(0, "R10 write idx20");
        mem_rd = 1; go(0, "R10 no write marker");
    endtask

    task automatic t_block();
        do_reset();
        dsto_en = 1; dsto_idx = 2; go(0, "R8 write r2");
        blk_store = 1; blk_last = 3; go(2, "R8 store 1 back");
        do_reset();
        dsto_en = 1; dsto_idx = 2; go(0, "R8 write r2");
        go(0, "R8 gap");
        blk_store = 1; blk_last = 3; go(1, "R8 store 2 back");
        do_reset();
        dsto_en = 1; dsto_idx = 9; go(0, "R8 write r9");
        blk_store = 1; blk_last = 3; go(0, "R8 outside range");
        blk_store = 1; blk_last = 7; blk_lo = 0; go(0, "R9 exact line");
        blk_store = 1; blk_last = 7; blk_lo = 4; go(1, "R9 one crossing");
        blk_store = 1; blk_last = 15; blk_lo = 4; go(2, "R9 two crossings");
        blk_load = 1; blk_last = 15; blk_lo = 0; go(1, "R9 load crossing");
    endtask

    task automatic t_combined();
        do_reset();
        dsto_en = 1; dsto_idx = 2; go(0, "R11 write r2");
        blk_store = 1; blk_last = 3; blk_lo = 5'd28; go(3, "R11 source plus line");
        do_reset();
        blk_load = 1; go(0, "R11 load r0");
        mem_rd = 1; addr_en = 1; addr_idx = 0; src_en = 1; src_idx = 0;
        go(3, "R11 max of hazards");
    endtask

    task automatic t_counters();
        do_reset();
        mem_wr = 1; go(0, "R13 write");
        mem_rd = 1; go(2, "R13 raw");
        blk_load = 1; blk_last = 1; blk_lo = 5'd28; go(1, "R13 load line");
        src_en = 1; src_idx = 1; go(3, "R13 load use");
        chk(stall_cnt_o[2*16 +: 16] == 16'd2, "R13 raw counter", int'(stall_cnt_o[2*16 +: 16]), 2);
        chk(stall_cnt_o[0 +: 16] == 16'd3, "R13 load-use counter", int'(stall_cnt_o[0 +: 16]), 3);
        chk(stall_cnt_o[7*16 +: 16] == 16'd1, "R13 line counter", int'(stall_cnt_o[7*16 +: 16]), 1);
        chk(stall_cnt_o[3*16 +: 16] == 16'd0, "R13 jump counter idle", int'(stall_cnt_o[3*16 +: 16]), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_loaduse();
        t_simple();
        t_jump_target();
        t_block();
        t_combined();
        t_counters();
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule